// File: doc/BRIEF.md
# Rounding Multiplier-Accumulator with Sectioned Preload

This block multiplies two 16-bit operands and folds the 32-bit product into a 35-bit accumulator. Both operands are read either as two's complement or as unsigned numbers. The product can be rounded at bit 15 before it is used. The accumulator can take the product directly, add the product to itself, or be replaced by the product minus its old value. Operands and mode controls sit in input registers. Three strobes on one system clock set when the A register, the B register and the accumulator load.

The accumulator is read out as three sections: a 3-bit extension, a 16-bit upper half and a 16-bit lower half. Each section has its own pad driver with an active-high disable. When a section is disabled and preload is requested, that section takes the value on its own pads at the next accumulator strobe. This lets software seed the accumulator through the result pins. The lower result pads also carry the B operand in. Each pad group is modelled as separate in, out and enable vectors.

Top module: `rmac_top`

## Requirements
- R1: While `rst` is high at a clock edge, all three accumulator sections, both operand registers and all captured controls clear to zero.
- R2: The A register captures `a_in` on an edge with `a_load` high, and the B register captures `lo_pad_in` on an edge with `b_load` high. Without its strobe, each register holds its value.
- R3: `tc`, `rnd`, `acc` and `sub` are captured on any edge where `a_load` or `b_load` is high, and otherwise hold. Arithmetic always uses the captured values.
- R4: With captured `tc`=1, both operands and the 32-bit product are signed, and the product is sign-extended to 35 bits. With `tc`=0, they are unsigned and the product is zero-extended.
- R5: With captured `rnd`=1, the value 2^15 is added to the extended product before accumulation.
- R6: Captured {acc,sub} chooses the new accumulator value: 10 gives product+acc, 11 gives product−acc, and 00 or 01 gives the product alone. All results are taken modulo 2^35.
- R7: The accumulator changes only on an edge with `res_load` high.
- R8: Accumulator bits 34:32 appear on `ext_pad_out`, bits 31:16 on `hi_pad_out` and bits 15:0 on `lo_pad_out`.
- R9: Each `*_pad_oe` vector is all ones when its `dis_*` input is low and all zeros when it is high, with no dependence on preload.
- R10: On a `res_load` edge with `prel` high, every section whose `dis_*` is high loads its own `*_pad_in` value. The remaining sections take their bits of the arithmetic result on the same edge.
- R11: With `prel` low, or with a section's disable low, that section takes the arithmetic result even while the other condition is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 16 | Operand A data |
| a_load | input | 1 | Capture strobe for operand A (also captures controls) |
| b_load | input | 1 | Capture strobe for operand B from `lo_pad_in` (also captures controls) |
| res_load | input | 1 | Accumulator update strobe |
| tc | input | 1 | 1 = two's complement operands, 0 = unsigned |
| rnd | input | 1 | Round the product at bit 15 |
| acc | input | 1 | Accumulate with the previous value |
| sub | input | 1 | With `acc`, form product minus accumulator |
| prel | input | 1 | Preload disabled sections from their pads |
| dis_ext | input | 1 | Disable the extension pad drivers |
| dis_hi | input | 1 | Disable the upper-half pad drivers |
| dis_lo | input | 1 | Disable the lower-half pad drivers |
| ext_pad_in | input | 3 | Extension pads, inbound value |
| ext_pad_out | output | 3 | Extension section value |
| ext_pad_oe | output | 3 | Extension pad drive enables |
| hi_pad_in | input | 16 | Upper-half pads, inbound value |
| hi_pad_out | output | 16 | Upper-half section value |
| hi_pad_oe | output | 16 | Upper-half pad drive enables |
| lo_pad_in | input | 16 | Lower-half pads, inbound value; also operand B |
| lo_pad_out | output | 16 | Lower-half section value |
| lo_pad_oe | output | 16 | Lower-half pad drive enables |

## Verification
The assertions assume every input is at a known level at each clock edge and that reset is held for at least one edge before checks start. The preload check also assumes the inbound pad value seen at the edge is what an external driver put on the pins, not the block's own output. The stimulus drives every input from time zero and keeps reset high for several edges. Inputs change only at the falling edge. While preloading, it always supplies explicit pad values for the disabled sections.

// File: rtl/rmac_pkg.sv
package rmac_pkg;

  typedef struct packed {
    logic tc;
    logic rnd;
    logic acc;
    logic sub;
  } rmac_ctrl_t;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_ADD  = 2'd1,
    OP_RSUB = 2'd2
  } rmac_op_e;

  // acc=0 selects a plain load regardless of sub (01 is treated as 00)
  function automatic rmac_op_e rmac_decode(input logic acc_i, input logic sub_i);
    if (!acc_i)      return OP_LOAD;
    else if (sub_i)  return OP_RSUB;
    else             return OP_ADD;
  endfunction

endpackage

// File: rtl/rmac_operand_regs.sv
module rmac_operand_regs
  import rmac_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            a_ld,
  input  logic            b_ld,
  input  logic [OP_W-1:0] a_d,
  input  logic [OP_W-1:0] b_d,
  input  rmac_ctrl_t      ctrl_d,
  output logic [OP_W-1:0] a_q,
  output logic [OP_W-1:0] b_q,
  output rmac_ctrl_t      ctrl_q
);

  logic ctrl_ld;
  assign ctrl_ld = a_ld | b_ld;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      ctrl_q <= '0;
    end else begin
      if (a_ld)    a_q    <= a_d;
      if (b_ld)    b_q    <= b_d;
      if (ctrl_ld) ctrl_q <= ctrl_d;
    end
  end

  assert_a_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !a_ld |=> $stable(a_q));
  assert_b_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !b_ld |=> $stable(b_q));
  assert_b_capture_R2: assert property (@(posedge clk) disable iff (rst)
    b_ld |=> b_q == $past(b_d));
  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(a_ld || b_ld) |=> $stable(ctrl_q));

endmodule

// File: rtl/rmac_arith.sv
module rmac_arith
  import rmac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int EXT_W = 3
) (
  input  logic [OP_W-1:0]          a,
  input  logic [OP_W-1:0]          b,
  input  rmac_ctrl_t               ctrl,
  input  logic [2*OP_W+EXT_W-1:0]  acc_cur,
  output logic [2*OP_W+EXT_W-1:0]  acc_nxt
);

  localparam int PROD_W = 2 * OP_W;
  localparam int ACC_W  = PROD_W + EXT_W;
  localparam logic [ACC_W-1:0] RND_BIT = ACC_W'(1) << (OP_W - 1);

  // one guard bit makes the same signed multiplier serve both modes
  logic signed [OP_W:0]     a_x, b_x;
  logic signed [PROD_W-1:0] a_w, b_w, prod;
  logic [ACC_W-1:0]         prod_ext, prod_rnd;
  rmac_op_e                 op;

  assign a_x = {ctrl.tc & a[OP_W-1], a};
  assign b_x = {ctrl.tc & b[OP_W-1], b};
  assign a_w = PROD_W'(a_x);
  assign b_w = PROD_W'(b_x);
  assign prod = a_w * b_w;

  assign prod_ext = {{EXT_W{ctrl.tc & prod[PROD_W-1]}}, prod};
  assign prod_rnd = prod_ext + (ctrl.rnd ? RND_BIT : '0);
  assign op       = rmac_decode(ctrl.acc, ctrl.sub);

  always_comb begin
    unique case (op)
      OP_ADD:  acc_nxt = prod_rnd + acc_cur;
      OP_RSUB: acc_nxt = prod_rnd - acc_cur;
      default: acc_nxt = prod_rnd;
    endcase
  end

endmodule

// File: rtl/rmac_section.sv
module rmac_section #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic         pre_en,
  input  logic [W-1:0] pad_d,
  input  logic [W-1:0] calc_d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (ld)  q <= pre_en ? pad_d : calc_d;
  end

  assert_sec_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(q));
  assert_sec_preload_R10: assert property (@(posedge clk) disable iff (rst)
    (ld && pre_en) |=> q == $past(pad_d));
  assert_sec_arith_R11: assert property (@(posedge clk) disable iff (rst)
    (ld && !pre_en) |=> q == $past(calc_d));

endmodule

// File: rtl/rmac_top.sv
module rmac_top
  import rmac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int EXT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  a_in,
  input  logic             a_load,
  input  logic             b_load,
  input  logic             res_load,
  input  logic             tc,
  input  logic             rnd,
  input  logic             acc,
  input  logic             sub,
  input  logic             prel,
  input  logic             dis_ext,
  input  logic             dis_hi,
  input  logic             dis_lo,
  input  logic [EXT_W-1:0] ext_pad_in,
  output logic [EXT_W-1:0] ext_pad_out,
  output logic [EXT_W-1:0] ext_pad_oe,
  input  logic [OP_W-1:0]  hi_pad_in,
  output logic [OP_W-1:0]  hi_pad_out,
  output logic [OP_W-1:0]  hi_pad_oe,
  input  logic [OP_W-1:0]  lo_pad_in,
  output logic [OP_W-1:0]  lo_pad_out,
  output logic [OP_W-1:0]  lo_pad_oe
);

  localparam int PROD_W = 2 * OP_W;
  localparam int ACC_W  = PROD_W + EXT_W;

  logic [OP_W-1:0]  a_q, b_q;
  rmac_ctrl_t       ctrl_d, ctrl_q;
  logic [ACC_W-1:0] acc_cur, acc_nxt;

  assign ctrl_d = '{tc: tc, rnd: rnd, acc: acc, sub: sub};

  rmac_operand_regs #(.OP_W(OP_W)) u_ops (
    .clk    (clk),
    .rst    (rst),
    .a_ld   (a_load),
    .b_ld   (b_load),
    .a_d    (a_in),
    .b_d    (lo_pad_in),
    .ctrl_d (ctrl_d),
    .a_q    (a_q),
    .b_q    (b_q),
    .ctrl_q (ctrl_q)
  );

  rmac_arith #(.OP_W(OP_W), .EXT_W(EXT_W)) u_arith (
    .a       (a_q),
    .b       (b_q),
    .ctrl    (ctrl_q),
    .acc_cur (acc_cur),
    .acc_nxt (acc_nxt)
  );

  rmac_section #(.W(EXT_W)) u_sec_ext (
    .clk    (clk),
    .rst    (rst),
    .ld     (res_load),
    .pre_en (prel & dis_ext),
    .pad_d  (ext_pad_in),
    .calc_d (acc_nxt[ACC_W-1:PROD_W]),
    .q      (ext_pad_out)
  );

  rmac_section #(.W(OP_W)) u_sec_hi (
    .clk    (clk),
    .rst    (rst),
    .ld     (res_load),
    .pre_en (prel & dis_hi),
    .pad_d  (hi_pad_in),
    .calc_d (acc_nxt[PROD_W-1:OP_W]),
    .q      (hi_pad_out)
  );

  rmac_section #(.W(OP_W)) u_sec_lo (
    .clk    (clk),
    .rst    (rst),
    .ld     (res_load),
    .pre_en (prel & dis_lo),
    .pad_d  (lo_pad_in),
    .calc_d (acc_nxt[OP_W-1:0]),
    .q      (lo_pad_out)
  );

  assign acc_cur    = {ext_pad_out, hi_pad_out, lo_pad_out};
  assign ext_pad_oe = {EXT_W{~dis_ext}};
  assign hi_pad_oe  = {OP_W{~dis_hi}};
  assign lo_pad_oe  = {OP_W{~dis_lo}};

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (acc_cur == '0 && a_q == '0 && b_q == '0));

endmodule

// File: tb/rmac_top_tb.sv
module rmac_top_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a_in = '0;
  logic        a_load = 0, b_load = 0, res_load = 0;
  logic        tc = 0, rnd = 0, acc = 0, sub = 0, prel = 0;
  logic        dis_ext = 0, dis_hi = 0, dis_lo = 0;
  logic [2:0]  ext_pad_in = '0;
  logic [15:0] hi_pad_in = '0, lo_pad_in = '0;
  logic [2:0]  ext_pad_out, ext_pad_oe;
  logic [15:0] hi_pad_out, hi_pad_oe, lo_pad_out, lo_pad_oe;

  int checks = 0;
  int errors = 0;
  bit mon_on = 0;
  string cur_req = "R8";

  // behavioural reference state
  logic [15:0] m_a, m_b;
  logic        m_tc, m_rnd, m_acc, m_sub;
  logic [34:0] m_res;

  always #10 clk = ~clk;

  rmac_top u_dut (
    .clk(clk), .rst(rst), .a_in(a_in), .a_load(a_load), .b_load(b_load),
    .res_load(res_load), .tc(tc), .rnd(rnd), .acc(acc), .sub(sub), .prel(prel),
    .dis_ext(dis_ext), .dis_hi(dis_hi), .dis_lo(dis_lo),
    .ext_pad_in(ext_pad_in), .ext_pad_out(ext_pad_out), .ext_pad_oe(ext_pad_oe),
    .hi_pad_in(hi_pad_in), .hi_pad_out(hi_pad_out), .hi_pad_oe(hi_pad_oe),
    .lo_pad_in(lo_pad_in), .lo_pad_out(lo_pad_out), .lo_pad_oe(lo_pad_oe)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [34:0] model_next();
    longint pa, pb, pr;
    logic [34:0] p35, nx;
    if (m_tc) begin
      pa = m_a[15] ? longint'(m_a) - 65536 : longint'(m_a);
      pb = m_b[15] ? longint'(m_b) - 65536 : longint'(m_b);
    end else begin
      pa = longint'(m_a);
      pb = longint'(m_b);
    end
    pr = pa * pb + (m_rnd ? 64'sd32768 : 64'sd0);
    p35 = pr[34:0];
    if (m_acc && !m_sub)     nx = p35 + m_res;
    else if (m_acc && m_sub) nx = p35 - m_res;
    else                     nx = p35;
    if (prel && dis_ext) nx[34:32] = ext_pad_in;
    if (prel && dis_hi)  nx[31:16] = hi_pad_in;
    if (prel && dis_lo)  nx[15:0]  = lo_pad_in;
    return nx;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_a = '0; m_b = '0; m_res = '0;
      {m_tc, m_rnd, m_acc, m_sub} = 4'b0;
    end else begin
      if (res_load) m_res = model_next();
      if (a_load) m_a = a_in;
      if (b_load) m_b = lo_pad_in;
      if (a_load || b_load) {m_tc, m_rnd, m_acc, m_sub} = {tc, rnd, acc, sub};
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    #2;
    if (mon_on) begin
      chk(cur_req, {29'd0, ext_pad_out, hi_pad_out, lo_pad_out}, {29'd0, m_res});
      chk("R9", {29'd0, ext_pad_oe, hi_pad_oe, lo_pad_oe},
          {29'd0, {3{~dis_ext}}, {16{~dis_hi}}, {16{~dis_lo}}});
    end
  end

  function automatic logic [34:0] dut_res();
    return {ext_pad_out, hi_pad_out, lo_pad_out};
  endfunction

  task automatic run_op(input logic [15:0] a, input logic [15:0] b,
                        input logic t, input logic r, input logic ac, input logic sb);
    @(negedge clk);
    a_in = a; lo_pad_in = b; tc = t; rnd = r; acc = ac; sub = sb;
    a_load = 1; b_load = 1; res_load = 0;
    @(negedge clk);
    a_load = 0; b_load = 0; res_load = 1;
    @(negedge clk);
    res_load = 0;
    #1;
  endtask

  task automatic strobe_res();
    @(negedge clk);
    res_load = 1;
    @(negedge clk);
    res_load = 0; prel = 0; dis_ext = 0; dis_hi = 0; dis_lo = 0;
    #1;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    #1;
    chk("R1", {29'd0, dut_res()}, 64'd0);
    mon_on = 1;

    cur_req = "R4";
    run_op(16'd3, 16'd5, 0, 0, 0, 0);
    chk("R4", {29'd0, dut_res()}, 64'd15);

    // R2/R3: change data and controls without strobes
    cur_req = "R3";
    @(negedge clk);
    a_in = 16'd7; lo_pad_in = 16'd9; tc = 1; rnd = 1; acc = 1; sub = 1;
    res_load = 1;
    @(negedge clk);
    res_load = 0;
    #1;
    chk("R2", {29'd0, dut_res()}, 64'd15);
    chk("R3", {29'd0, dut_res()}, 64'd15);

    cur_req = "R4";
    run_op(16'hFFFF, 16'hFFFF, 1, 0, 0, 0);
    chk("R4", {29'd0, dut_res()}, 64'd1);
    run_op(16'hFFFF, 16'hFFFF, 0, 0, 0, 0);
    chk("R4", {29'd0, dut_res()}, 64'h0_FFFE_0001);
    run_op(16'hFFFF, 16'd2, 1, 0, 0, 0);
    chk("R4", {29'd0, dut_res()}, 64'h7_FFFF_FFFE);

    cur_req = "R5";
    run_op(16'd1, 16'h8000, 0, 1, 0, 0);
    chk("R5", {29'd0, dut_res()}, 64'h1_0000);
    run_op(16'd1, 16'h7FFF, 0, 1, 0, 0);
    chk("R5", {29'd0, dut_res()}, 64'h0_FFFF);

    cur_req = "R6";
    run_op(16'd3, 16'd5, 0, 0, 0, 0);
    run_op(16'd3, 16'd5, 0, 0, 1, 0);
    chk("R6", {29'd0, dut_res()}, 64'd30);
    run_op(16'd1, 16'd1, 0, 0, 1, 1);
    chk("R6", {29'd0, dut_res()}, 64'h7_FFFF_FFE3);
    run_op(16'd2, 16'd2, 0, 0, 0, 1);
    chk("R6", {29'd0, dut_res()}, 64'd4);

    // R8: section mapping
    cur_req = "R8";
    run_op(16'h1234, 16'h0100, 0, 0, 0, 0);
    chk("R8", {48'd0, hi_pad_out}, 64'h0012);
    chk("R8", {48'd0, lo_pad_out}, 64'h3400);

    // R10: full preload to all ones, outputs disabled
    cur_req = "R10";
    @(negedge clk);
    prel = 1; dis_ext = 1; dis_hi = 1; dis_lo = 1;
    ext_pad_in = 3'h7; hi_pad_in = 16'hFFFF; lo_pad_in = 16'hFFFF;
    #1;
    chk("R9", {29'd0, ext_pad_oe, hi_pad_oe, lo_pad_oe}, 64'd0);
    strobe_res();
    chk("R10", {29'd0, dut_res()}, 64'h7_FFFF_FFFF);

    // R7: wrap modulo 2^35
    cur_req = "R7";
    run_op(16'd1, 16'd1, 0, 0, 1, 0);
    chk("R7", {29'd0, dut_res()}, 64'd0);
    repeat (3) @(negedge clk);
    #1;
    chk("R7", {29'd0, dut_res()}, 64'd0);

    // R10: only the upper half preloads; controls held at add, operands 1*1
    cur_req = "R10";
    @(negedge clk);
    prel = 1; dis_hi = 1; hi_pad_in = 16'h1234;
    strobe_res();
    chk("R10", {29'd0, dut_res()}, 64'h0_1234_0001);

    // R11: preload requested but no section disabled
    cur_req = "R11";
    @(negedge clk);
    prel = 1; hi_pad_in = 16'hAAAA; lo_pad_in = 16'h5555;
    #1;
    chk("R9", {29'd0, ext_pad_oe, hi_pad_oe, lo_pad_oe}, 64'h7_FFFF_FFFF);
    strobe_res();
    chk("R11", {29'd0, dut_res()}, 64'h0_1234_0002);
    // disabled without preload: arithmetic still loads
    @(negedge clk);
    dis_lo = 1; lo_pad_in = 16'h5555;
    #1;
    chk("R9", {48'd0, lo_pad_oe}, 64'd0);
    strobe_res();
    chk("R11", {29'd0, dut_res()}, 64'h0_1234_0003);

    // random traffic compared every cycle with the model
    cur_req = "R8";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      a_in = 16'($urandom); lo_pad_in = 16'($urandom); hi_pad_in = 16'($urandom);
      ext_pad_in = 3'($urandom);
      {a_load, b_load, res_load} = 3'($urandom);
      {tc, rnd, acc, sub} = 4'($urandom);
      prel = ($urandom % 4) == 0;
      {dis_ext, dis_hi, dis_lo} = 3'($urandom);
    end
    @(negedge clk);
    {a_load, b_load, res_load, prel} = 4'b0;

    // R1: reset mid-run clears everything
    cur_req = "R1";
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    #1;
    chk("R1", {29'd0, dut_res()}, 64'd0);
    strobe_res();
    chk("R1", {29'd0, dut_res()}, 64'd0);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule